// File: doc/BRIEF.md
# Bidirectional Variable-Speed Light Rotator

This block lights a ring of six lamps, for example the outer segments of a seven-segment digit, so that one lit spot travels around the ring. Between two single-lamp positions the block inserts a short overlap step in which both neighbouring lamps are on. The ring therefore has twelve steps. Even steps light one lamp and odd steps light two adjacent lamps. A direction switch picks the travel sense. A raw pushbutton, after debouncing, moves through a list of six dwell times for the single-lamp steps. The overlap steps always last 20 ms.

All timing runs on a 1 ms enable pulse. The block makes this pulse by dividing the system clock by `TICK_DIV`. The pushbutton is synchronised and then debounced on the same 1 ms pulse. Each accepted press advances a speed index. A down-counter holds the rotator in each step. The counter reloads on every step entry from the interval that applies to the new step, so a new direction or speed only takes effect at the next step boundary.

Top module: `lrot_top`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to step 0 with only lamp 0 lit (`lamps` = 6'b000001), and the speed selection returns to 250 ms.
- R2: One millisecond is exactly `TICK_DIV` system clocks. After reset is released, the first change of `lamps` appears exactly 250·`TICK_DIV` clocks later.
- R3: With `dir_cw` = 1 the block steps through 0,1,2,…,11,0. Step 2k lights only lamp k. Step 2k+1 lights lamps k and (k+1) mod 6.
- R4: With `dir_cw` = 0 the block walks the same twelve steps in reverse order, 11 after 0.
- R5: Every single-lamp step lasts the selected interval in ms.
- R6: Every overlap step lasts exactly 20 ms, whatever speed is selected.
- R7: Each accepted press moves the speed selection one place along the list 250, 180, 130, 100, 70, 40 ms. After 40 ms it wraps back to 250 ms.
- R8: The debounced button level changes only after the synchronised input has differed from it on 10 consecutive 1 ms ticks. Only a change to the pressed level counts as a press. Shorter pulses, bounces and releases do not change the speed.
- R9: A change of `dir_cw` or of the speed during a step leaves that step's remaining time unchanged. The change applies from the next step entry on.
- R10: At every cycle either one lamp is lit, or exactly two adjacent lamps are lit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| dir_cw | input | 1 | Travel sense: 1 steps upward through the lamps, 0 steps downward |
| speed_btn | input | 1 | Raw, undebounced speed pushbutton, high when pressed |
| lamps | output | 6 | Lamp drive, bit k lights lamp k |

## Verification
The bench builds the block with `TICK_DIV` = 4, so one millisecond is four clocks. The debounce length and the overlap time keep their default values of 10 and 20. With this divider, full rotations in both directions, all six speeds and their wrap, pulses that are too short, bouncing inputs and mid-step changes of direction and speed all fit in well under a hundred thousand clocks. Dwell times are measured in exact clock counts, so an error of a single tick or a single clock shows up.

// File: rtl/lrot_pkg.sv
package lrot_pkg;

  localparam int unsigned RING    = 6;
  localparam int unsigned NSTATES = 2 * RING;
  localparam int unsigned NSPEEDS = 6;
  localparam int unsigned POS_W   = $clog2(NSTATES);
  localparam int unsigned SPD_W   = $clog2(NSPEEDS);
  localparam int unsigned MS_W    = 9;

  typedef logic [POS_W-1:0] pos_t;
  typedef logic [SPD_W-1:0] spd_t;
  typedef logic [MS_W-1:0]  ms_t;
  typedef logic [RING-1:0]  ring_t;

  // dwell of a single-lamp step for a speed index
  function automatic ms_t single_ms(spd_t s);
    case (s)
      spd_t'(0): return ms_t'(250);
      spd_t'(1): return ms_t'(180);
      spd_t'(2): return ms_t'(130);
      spd_t'(3): return ms_t'(100);
      spd_t'(4): return ms_t'(70);
      spd_t'(5): return ms_t'(40);
      default:   return ms_t'(250);
    endcase
  endfunction

  function automatic spd_t next_speed(spd_t s);
    return (s == spd_t'(NSPEEDS - 1)) ? '0 : s + spd_t'(1);
  endfunction

  function automatic pos_t step_pos(pos_t p, logic cw);
    if (cw) return (p == pos_t'(NSTATES - 1)) ? '0 : p + pos_t'(1);
    else    return (p == '0) ? pos_t'(NSTATES - 1) : p - pos_t'(1);
  endfunction

  // lamp pattern of a step: even = one lamp, odd = lamp and its upper neighbour
  function automatic ring_t lamps_of(pos_t p);
    int unsigned k;
    ring_t v;
    k = 32'(p) >> 1;
    v = ring_t'(1) << k;
    if (p[0]) v = v | (ring_t'(1) << ((k + 1) % RING));
    return v;
  endfunction

endpackage

// File: rtl/lrot_tick_gen.sv
module lrot_tick_gen #(
  parameter int unsigned DIV = 50000
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
    32'(cnt_q) < DIV);

  generate
    if (DIV > 1) begin : g_gap
      assert_tick_gap_R2: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/lrot_debounce.sv
module lrot_debounce #(
  parameter int unsigned HOLD_TICKS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic raw_i,
  output logic rise_o
);
  localparam int unsigned HW = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;

  logic [1:0]    sync_q;
  logic          level_q;
  logic [HW-1:0] run_q;

  logic synced, differ, settle;

  assign synced = sync_q[1];
  assign differ = synced ^ level_q;
  assign settle = tick_i && differ && (run_q == HW'(HOLD_TICKS - 1));
  assign rise_o = settle && synced;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= '0;
      level_q <= 1'b0;
      run_q   <= '0;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (tick_i) begin
        if (!differ) begin
          run_q <= '0;
        end else if (settle) begin
          level_q <= synced;
          run_q   <= '0;
        end else begin
          run_q <= run_q + HW'(1);
        end
      end
    end
  end

  assert_rise_sets_level_R8: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> level_q);

  assert_level_on_tick_R8: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(level_q));

  assert_run_bound_R8: assert property (@(posedge clk) disable iff (rst)
    32'(run_q) < HOLD_TICKS);

endmodule

// File: rtl/lrot_speed_sel.sv
module lrot_speed_sel
  import lrot_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic step_i,
  output ms_t  single_ms_o
);
  spd_t idx_q;

  always_ff @(posedge clk) begin
    if (rst)         idx_q <= '0;
    else if (step_i) idx_q <= next_speed(idx_q);
  end

  assign single_ms_o = single_ms(idx_q);

  assert_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (step_i && idx_q == spd_t'(NSPEEDS - 1)) |=> (idx_q == '0));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(idx_q));

  assert_range_R7: assert property (@(posedge clk) disable iff (rst)
    32'(idx_q) < NSPEEDS);

endmodule

// File: rtl/lrot_ring_fsm.sv
module lrot_ring_fsm
  import lrot_pkg::*;
#(
  parameter int unsigned OVERLAP_MS = 20
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  tick_i,
  input  logic  cw_i,
  input  ms_t   single_ms_i,
  output ring_t lamps_o
);
  pos_t pos_q, pos_nx;
  ms_t  left_q, load_ms;
  logic step_evt;

  assign pos_nx   = step_pos(pos_q, cw_i);
  assign step_evt = tick_i && (left_q == ms_t'(1));
  assign load_ms  = pos_nx[0] ? ms_t'(OVERLAP_MS) : single_ms_i;
  assign lamps_o  = lamps_of(pos_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= '0;
      left_q <= single_ms(spd_t'(0));
    end else if (step_evt) begin
      pos_q  <= pos_nx;
      left_q <= load_ms;
    end else if (tick_i) begin
      left_q <= left_q - ms_t'(1);
    end
  end

  assert_lamp_count_R10: assert property (@(posedge clk) disable iff (rst)
    ($countones(lamps_o) == 1) || ($countones(lamps_o) == 2));

  assert_cw_step_R3: assert property (@(posedge clk) disable iff (rst)
    ((pos_q != $past(pos_q)) && $past(cw_i))
      |-> (pos_q == pos_t'((32'($past(pos_q)) + 1) % NSTATES)));

  assert_ccw_step_R4: assert property (@(posedge clk) disable iff (rst)
    ((pos_q != $past(pos_q)) && !$past(cw_i))
      |-> (pos_q == pos_t'((32'($past(pos_q)) + NSTATES - 1) % NSTATES)));

  assert_overlap_load_R6: assert property (@(posedge clk) disable iff (rst)
    ((pos_q != $past(pos_q)) && pos_q[0]) |-> (left_q == ms_t'(OVERLAP_MS)));

  assert_dwell_live_R5: assert property (@(posedge clk) disable iff (rst)
    left_q != '0);

  assert_move_on_tick_R9: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(pos_q));

endmodule

// File: rtl/lrot_top.sv
module lrot_top
  import lrot_pkg::*;
#(
  parameter int unsigned TICK_DIV    = 50000,
  parameter int unsigned DEBOUNCE_MS = 10,
  parameter int unsigned OVERLAP_MS  = 20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       dir_cw,
  input  logic       speed_btn,
  output logic [5:0] lamps
);
  logic  tick_ms;
  logic  press_evt;
  ms_t   dwell_single;
  ring_t ring_lamps;

  lrot_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick_ms)
  );

  lrot_debounce #(.HOLD_TICKS(DEBOUNCE_MS)) u_deb (
    .clk    (clk),
    .rst    (rst),
    .tick_i (tick_ms),
    .raw_i  (speed_btn),
    .rise_o (press_evt)
  );

  lrot_speed_sel u_speed (
    .clk         (clk),
    .rst         (rst),
    .step_i      (press_evt),
    .single_ms_o (dwell_single)
  );

  lrot_ring_fsm #(.OVERLAP_MS(OVERLAP_MS)) u_ring (
    .clk         (clk),
    .rst         (rst),
    .tick_i      (tick_ms),
    .cw_i        (dir_cw),
    .single_ms_i (dwell_single),
    .lamps_o     (ring_lamps)
  );

  assign lamps = ring_lamps;

  assert_press_on_tick_R8: assert property (@(posedge clk) disable iff (rst)
    press_evt |-> tick_ms);

endmodule

// File: tb/lrot_top_test.sv
module lrot_top_test;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dir_cw = 1'b1;
  logic       speed_btn = 1'b0;
  logic [5:0] lamps;

  int  vectors = 0;
  int  fails = 0;
  int  b_idx = 0;
  bit  b_dir = 1'b1;
  bit  timed = 1'b1;
  int  last_n = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  lrot_top #(.TICK_DIV(DIV)) uut (
    .clk(clk), .rst(rst), .dir_cw(dir_cw), .speed_btn(speed_btn), .lamps(lamps)
  );

  function automatic int spd(int i);
    int t[6] = '{250, 180, 130, 100, 70, 40};
    return t[i % 6];
  endfunction

  function automatic logic [5:0] pat(int p);
    logic [11:0] dbl;
    dbl = (p % 2 == 0) ? 12'b1 : 12'b11;
    dbl = dbl << (p / 2);
    return dbl[5:0] | dbl[11:6];
  endfunction

  function automatic int pos_of(logic [5:0] v);
    for (int p = 0; p < 12; p++) if (v == pat(p)) return p;
    return -1;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_ms(int ms);
    repeat (ms * DIV) @(negedge clk);
  endtask

  // wait for the next lamp change, check direction, pattern and dwell
  task automatic step();
    logic [5:0] prev;
    int n, pp, pn, exp_p, exp_d;
    bit was_single;
    prev = lamps;
    pp = pos_of(prev);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (lamps == prev);
    pn = pos_of(lamps);
    chk(pn >= 0, "R10 lamp pattern", int'(lamps), int'(pat(0)));
    exp_p = (pp + (b_dir ? 1 : 11)) % 12;
    chk(pn == exp_p, b_dir ? "R3 cw step" : "R4 ccw step", pn, exp_p);
    was_single = (pp % 2 == 0);
    exp_d = (was_single ? spd(b_idx) : 20) * DIV;
    if (timed)
      chk(n == exp_d, was_single ? "R5/R7 single dwell" : "R6 overlap dwell", n, exp_d);
    last_n = n;
    timed = 1'b1;
  endtask

  task automatic press_once();
    timed = 1'b0;
    speed_btn = 1'b1;
    wait_ms(12);
    speed_btn = 1'b0;
    wait_ms(12);
    b_idx = (b_idx + 1) % 6;
  endtask

  task automatic set_dir(bit d);
    dir_cw = d;
    b_dir = d;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin : main
    int waited, k;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    chk(lamps == 6'b000001, "R1 reset lamps", int'(lamps), 1);
    rst = 1'b0;

    // R2: first change exactly 250 ms after release, then a full cw rotation (R3)
    step();
    chk(last_n == 250 * DIV, "R2 first dwell clocks", last_n, 250 * DIV);
    for (int i = 0; i < 11; i++) step();
    chk(lamps == 6'b000001, "R3 wrap to lamp 0", int'(lamps), 1);

    // R4: reverse rotation
    set_dir(1'b0);
    for (int i = 0; i < 12; i++) step();
    chk(lamps == 6'b000001, "R4 reverse wrap to lamp 0", int'(lamps), 1);

    // R7: walk every speed and wrap
    set_dir(1'b1);
    for (int i = 0; i < 7; i++) begin
      press_once();
      step(); step(); step();
    end
    chk(b_idx == 1, "R7 bench index after wrap", b_idx, 1);

    // R8: short pulse ignored
    timed = 1'b0;
    speed_btn = 1'b1; wait_ms(6); speed_btn = 1'b0; wait_ms(12);
    step(); step(); step();
    // R8: bouncing input then a steady press counts once
    timed = 1'b0;
    for (int i = 0; i < 10; i++) begin
      speed_btn = ~speed_btn;
      wait_ms(3);
    end
    speed_btn = 1'b1; wait_ms(15);
    speed_btn = 1'b0; wait_ms(15);
    b_idx = (b_idx + 1) % 6;
    step(); step(); step();
    // R8: long hold still counts once
    timed = 1'b0;
    speed_btn = 1'b1; wait_ms(60);
    speed_btn = 1'b0; wait_ms(15);
    b_idx = (b_idx + 1) % 6;
    step(); step(); step();

    // R9: mid-step change of direction and speed
    while (b_idx != 0) press_once();
    step(); step();
    while (pos_of(lamps) % 2 != 0) step();
    waited = 30;
    wait_ms(30);
    set_dir(~b_dir);
    press_once();
    waited += 24;
    timed = 1'b0;
    step();
    chk(last_n + waited * DIV == 250 * DIV, "R9 remaining dwell kept", last_n + waited * DIV, 250 * DIV);
    step();
    step();
    chk(last_n == 180 * DIV, "R9 new speed at next entry", last_n, 180 * DIV);

    // random mix of presses and direction
    for (int i = 0; i < 8; i++) begin
      k = int'($urandom % 4);
      set_dir(1'($urandom % 2));
      timed = 1'b0;
      for (int j = 0; j < k; j++) press_once();
      step(); step(); step();
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule